// File: doc/BRIEF.md
# Three-Minimum Magnitude Selector

This block looks at a whole word of soft-value magnitudes in one go and reports the three smallest, together with the input position of each. A soft-input soft-output block decoder uses these positions as its least reliable bits when it builds test patterns. The selection is a partial sort. A chain of halving shuffle stages sends the smaller value of each pair downward and the larger value upward. A small minimum tree on each upper section keeps the single value that section could still contribute. A short local selection over those survivors then picks second and third place.

Every comparison acts on a key made of the magnitude followed by the input index. Equal magnitudes are therefore ordered by position, and the three reported positions are always distinct. A generate option chooses the output style. In the registered style, results appear one clock after a cycle with the input valid high, and they hold while valid stays low. In the combinational style, the outputs follow the inputs directly.

Top module: `min3_select`

## Requirements
- R1: `min1_mag`/`min1_idx` give the smallest magnitude of `mag_in` and its lane index; lane i occupies bits [i*MAG_W +: MAG_W].
- R2: `min2_mag`/`min2_idx` give the second smallest entry under the same ordering as R1.
- R3: `min3_mag`/`min3_idx` give the third smallest entry under the same ordering as R1.
- R4: Entries are ranked by magnitude first and by lower lane index second. When all lanes are equal, the reported indices are 0, 1 and 2, and the three indices are always distinct.
- R5: In registered mode, `out_valid` is high in exactly the cycle that follows a rising clock edge at which `in_valid` was high. The results of the magnitudes sampled at that edge are on the outputs in the same cycle.
- R6: In registered mode, a clock edge with `in_valid` low leaves every result output unchanged, whatever `mag_in` carries.
- R7: While `rst_n` is low, `out_valid` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `mag_in` as a word to be ranked |
| mag_in | input | N_IN*MAG_W | Packed magnitudes, lane i at [i*MAG_W +: MAG_W] |
| out_valid | output | 1 | Results on the outputs are fresh |
| min1_mag | output | MAG_W | Smallest magnitude |
| min1_idx | output | IDX_W | Lane of the smallest magnitude |
| min2_mag | output | MAG_W | Second smallest magnitude |
| min2_idx | output | IDX_W | Lane of the second smallest magnitude |
| min3_mag | output | MAG_W | Third smallest magnitude |
| min3_idx | output | IDX_W | Lane of the third smallest magnitude |

## Verification
A wrongly wired pairing or a swapped compare-and-select direction drops a true minimum from its candidate set. The port then shows a larger magnitude, or a repeated or misordered index, one cycle after the word is presented. Heavy-tie words with magnitudes drawn from a four-value range expose any comparison that ignores the index, because equal magnitudes then come out with the wrong lane. Directed words place the three minima as partners in one stage, as the lone survivor of the last stage, and at the extremes of the lane range, so that each candidate path is exercised. Hold cycles drive a different word with valid low and would reveal a register that captures on every edge.

// File: rtl/m3s_pkg.sv
package m3s_pkg;

   typedef enum logic {
      M3S_OUT_COMB = 1'b0,
      M3S_OUT_REG  = 1'b1
   } m3s_out_e;

   function automatic bit m3s_pow2(input int value);
      return (value > 0) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/m3s_cs.sv
module m3s_cs #(
   parameter int KEY_W = 10
) (
   input  logic [KEY_W-1:0] key_a,
   input  logic [KEY_W-1:0] key_b,
   output logic [KEY_W-1:0] key_lo,
   output logic [KEY_W-1:0] key_hi
);

   logic a_smaller;

   assign a_smaller = key_a < key_b;
   assign key_lo    = a_smaller ? key_a : key_b;
   assign key_hi    = a_smaller ? key_b : key_a;

endmodule

// File: rtl/m3s_min_tree.sv
module m3s_min_tree #(
   parameter int KEY_W = 10,
   parameter int CNT   = 16
) (
   input  logic [KEY_W-1:0] keys [CNT],
   output logic [KEY_W-1:0] key_min
);

   localparam int NODES = 2 * CNT - 1;

   logic [KEY_W-1:0] node [NODES];

   for (genvar l = 0; l < CNT; l++) begin : g_leaf
      assign node[CNT-1+l] = keys[l];
   end

   for (genvar i = 0; i < CNT - 1; i++) begin : g_node
      assign node[i] = (node[2*i+1] < node[2*i+2]) ? node[2*i+1] : node[2*i+2];
   end

   assign key_min = node[0];

endmodule

// File: rtl/m3s_top2.sv
module m3s_top2 #(
   parameter int KEY_W = 10,
   parameter int CNT   = 5
) (
   input  logic [KEY_W-1:0] keys [CNT],
   output logic [KEY_W-1:0] key_first,
   output logic [KEY_W-1:0] key_second
);

   if (CNT < 2) begin : g_bad_cnt
      $error("m3s_top2 needs at least two candidates");
   end

   always_comb begin
      if (keys[0] < keys[1]) begin
         key_first  = keys[0];
         key_second = keys[1];
      end else begin
         key_first  = keys[1];
         key_second = keys[0];
      end
      for (int c = 2; c < CNT; c++) begin
         if (keys[c] < key_first) begin
            key_second = key_first;
            key_first  = keys[c];
         end else if (keys[c] < key_second) begin
            key_second = keys[c];
         end
      end
   end

endmodule

// File: rtl/m3s_net.sv
module m3s_net #(
   parameter int N_IN  = 32,
   parameter int MAG_W = 5
) (
   input  logic [N_IN*MAG_W-1:0]              mags,
   output logic [MAG_W+$clog2(N_IN)-1:0]      key_first,
   output logic [MAG_W+$clog2(N_IN)-1:0]      key_second,
   output logic [MAG_W+$clog2(N_IN)-1:0]      key_third
);

   localparam int IDX_W  = $clog2(N_IN);
   localparam int KEY_W  = MAG_W + IDX_W;
   localparam int STAGES = IDX_W;
   localparam int LANES  = 2 * N_IN - 1;

   // lane holds the stage inputs followed by every lower section in turn
   logic [KEY_W-1:0] lane [LANES];
   logic [KEY_W-1:0] cand [STAGES];

   for (genvar i = 0; i < N_IN; i++) begin : g_key
      assign lane[i] = {mags[i*MAG_W +: MAG_W], IDX_W'(i)};
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int HALF     = N_IN >> (s + 1);
      localparam int IN_BASE  = 2 * N_IN - 2 * (N_IN >> s);
      localparam int OUT_BASE = IN_BASE + (N_IN >> s);

      logic [KEY_W-1:0] upper [HALF];

      for (genvar j = 0; j < HALF; j++) begin : g_pair
         m3s_cs #(.KEY_W(KEY_W)) u_cs (
            .key_a  (lane[IN_BASE+j]),
            .key_b  (lane[IN_BASE+j+HALF]),
            .key_lo (lane[OUT_BASE+j]),
            .key_hi (upper[j])
         );
      end

      m3s_min_tree #(.KEY_W(KEY_W), .CNT(HALF)) u_tree (
         .keys    (upper),
         .key_min (cand[s])
      );
   end

   assign key_first = lane[LANES-1];

   m3s_top2 #(.KEY_W(KEY_W), .CNT(STAGES)) u_top2 (
      .keys       (cand),
      .key_first  (key_second),
      .key_second (key_third)
   );

   // R1: every stage survivor must rank behind the lower-section winner
   always_comb begin
      for (int s = 0; s < STAGES; s++) begin
         a_winner_below_cand_r1: assert (cand[s] > key_first)
            else $error("stage %0d candidate not above overall minimum", s);
      end
   end

endmodule

// File: rtl/min3_select.sv
module min3_select
   import m3s_pkg::*;
#(
   parameter int       N_IN     = 32,
   parameter int       MAG_W    = 5,
   parameter m3s_out_e OUT_MODE = M3S_OUT_REG,
   localparam int      IDX_W    = $clog2(N_IN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [N_IN*MAG_W-1:0]   mag_in,
   output logic                    out_valid,
   output logic [MAG_W-1:0]        min1_mag,
   output logic [IDX_W-1:0]        min1_idx,
   output logic [MAG_W-1:0]        min2_mag,
   output logic [IDX_W-1:0]        min2_idx,
   output logic [MAG_W-1:0]        min3_mag,
   output logic [IDX_W-1:0]        min3_idx
);

   localparam int KEY_W = MAG_W + IDX_W;

   if (!m3s_pow2(N_IN) || N_IN < 4) begin : g_bad_n
      $error("N_IN must be a power of two of at least 4");
   end
   if (MAG_W < 1) begin : g_bad_w
      $error("MAG_W must be at least 1");
   end

   logic [KEY_W-1:0] net_k1, net_k2, net_k3;
   logic [KEY_W-1:0] out_k1, out_k2, out_k3;

   m3s_net #(.N_IN(N_IN), .MAG_W(MAG_W)) u_net (
      .mags       (mag_in),
      .key_first  (net_k1),
      .key_second (net_k2),
      .key_third  (net_k3)
   );

   if (OUT_MODE == M3S_OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_k1    <= '0;
            out_k2    <= '0;
            out_k3    <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_k1 <= net_k1;
               out_k2 <= net_k2;
               out_k3 <= net_k3;
            end
         end
      end

      p_valid_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_valid_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable({out_k1, out_k2, out_k3}));
      p_rank_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_k1 < out_k2) && (out_k2 < out_k3));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_k1    = net_k1;
      assign out_k2    = net_k2;
      assign out_k3    = net_k3;
   end

   assign {min1_mag, min1_idx} = out_k1;
   assign {min2_mag, min2_idx} = out_k2;
   assign {min3_mag, min3_idx} = out_k3;

endmodule

// File: tb/test_min3_select.sv
module test_min3_select;

   localparam int N  = 32;
   localparam int MW = 5;
   localparam int IW = 5;
   localparam int BW = N * MW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [BW-1:0] mag_in;
   logic          out_valid;
   logic [MW-1:0] min1_mag, min2_mag, min3_mag;
   logic [IW-1:0] min1_idx, min2_idx, min3_idx;

   int errs   = 0;
   int checks = 0;

   always #5 clk = ~clk;

   min3_select i_min3_select (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .mag_in    (mag_in),
      .out_valid (out_valid),
      .min1_mag  (min1_mag),
      .min1_idx  (min1_idx),
      .min2_mag  (min2_mag),
      .min2_idx  (min2_idx),
      .min3_mag  (min3_mag),
      .min3_idx  (min3_idx)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scan reference: pick the smallest {mag,idx} not yet taken, three times
   function automatic logic [29:0] ref3(input logic [BW-1:0] b);
      logic [29:0] res = '0;
      bit taken [N];
      for (int i = 0; i < N; i++) taken[i] = 1'b0;
      for (int k = 0; k < 3; k++) begin
         logic [9:0] best = '0;
         int         bi   = -1;
         for (int i = 0; i < N; i++) begin
            logic [9:0] key = {b[i*MW +: MW], IW'(i)};
            if (!taken[i] && (bi < 0 || key < best)) begin
               best = key;
               bi   = i;
            end
         end
         taken[bi] = 1'b1;
         res[29-10*k -: 10] = best;
      end
      return res;
   endfunction

   task automatic run_vec(input logic [BW-1:0] b);
      logic [29:0] exp = ref3(b);
      @(negedge clk);
      mag_in   = b;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R5 valid after strobe", 32'(out_valid), 32'd1);
      chk({min1_mag, min1_idx} == exp[29:20], "R1 first", 32'({min1_mag, min1_idx}), 32'(exp[29:20]));
      chk({min2_mag, min2_idx} == exp[19:10], "R2 second", 32'({min2_mag, min2_idx}), 32'(exp[19:10]));
      chk({min3_mag, min3_idx} == exp[9:0], "R3 third", 32'({min3_mag, min3_idx}), 32'(exp[9:0]));
      mag_in = ~b;
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 valid drops", 32'(out_valid), 32'd0);
      chk({min1_mag, min1_idx, min2_mag, min2_idx, min3_mag, min3_idx} == exp,
          "R6 hold with valid low",
          32'({min1_mag, min1_idx, min2_mag, min2_idx, min3_mag, min3_idx}), 32'(exp));
   endtask

   function automatic logic [BW-1:0] fill(input int v);
      logic [BW-1:0] b;
      for (int i = 0; i < N; i++) b[i*MW +: MW] = MW'(v);
      return b;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [BW-1:0] b;
      void'($urandom(32'd20240917));
      rst_n    = 1'b0;
      in_valid = 1'b0;
      mag_in   = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 reset valid", 32'(out_valid), 32'd0);
      chk({min1_mag, min1_idx, min2_mag, min2_idx, min3_mag, min3_idx} == '0,
          "R7 reset results",
          32'({min1_mag, min1_idx, min2_mag, min2_idx, min3_mag, min3_idx}), 32'd0);
      rst_n = 1'b1;

      // ascending lanes
      for (int i = 0; i < N; i++) b[i*MW +: MW] = MW'(i);
      run_vec(b);
      // descending lanes: minima at the top of the index range
      for (int i = 0; i < N; i++) b[i*MW +: MW] = MW'(N - 1 - i);
      run_vec(b);
      // R4: all equal, positions decide
      run_vec(fill(7));
      chk({min1_idx, min2_idx, min3_idx} == {5'd0, 5'd1, 5'd2}, "R4 all-equal indices",
          32'({min1_idx, min2_idx, min3_idx}), 32'({5'd0, 5'd1, 5'd2}));
      // first and second minimum are partners in the first stage
      b = fill(20);
      b[0*MW +: MW]  = 5'd1;
      b[16*MW +: MW] = 5'd2;
      b[8*MW +: MW]  = 5'd3;
      run_vec(b);
      chk({min1_idx, min2_idx, min3_idx} == {5'd0, 5'd16, 5'd8}, "R2 partner minima",
          32'({min1_idx, min2_idx, min3_idx}), 32'({5'd0, 5'd16, 5'd8}));
      // R4: tie on magnitude between first and second, lower lane first
      b = fill(31);
      b[30*MW +: MW] = 5'd4;
      b[3*MW +: MW]  = 5'd4;
      b[17*MW +: MW] = 5'd9;
      run_vec(b);
      chk({min1_idx, min2_idx, min3_idx} == {5'd3, 5'd30, 5'd17}, "R4 tie lower lane first",
          32'({min1_idx, min2_idx, min3_idx}), 32'({5'd3, 5'd30, 5'd17}));
      // all maximum
      run_vec(fill(31));

      // random: full range, heavy ties, sparse small values
      for (int n = 0; n < 150; n++) begin
         for (int i = 0; i < N; i++) b[i*MW +: MW] = MW'($urandom_range(0, 31));
         run_vec(b);
      end
      for (int n = 0; n < 150; n++) begin
         for (int i = 0; i < N; i++) b[i*MW +: MW] = MW'($urandom_range(0, 3));
         run_vec(b);
      end
      for (int n = 0; n < 60; n++) begin
         b = fill(31);
         for (int k = 0; k < 4; k++) b[$urandom_range(0, N - 1)*MW +: MW] = MW'($urandom_range(0, 30));
         run_vec(b);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule